// File: doc/BRIEF.md
# Vector Tree Reduction Engine

This block adds up a stream of integers of any length by re-associating the sum. A bank of VL lane accumulators is cleared when a job starts; the element stream then arrives VL elements per beat, and each element is added into the accumulator of its own lane. When the last beat has been taken, the block folds the bank in halves. In each fold the upper half of the still-active accumulators is added onto the lower half. After log2(VL) folds one value is left, and it is presented with a one-cycle valid pulse.

The caller pulses a start strobe together with the total element count, then streams beats over a valid/ready handshake. If the count is not a multiple of VL, the lanes of the final beat that lie beyond the count are treated as zero. Arithmetic wraps modulo 2^DW. A job with a count of zero streams nothing and returns zero.

Top module: `vec_tree_reduce`

## Requirements
- R1: While reset is held and in the first cycle after it, `sum_valid_o` and `elem_ready_o` are 0.
- R2: A start pulse with a nonzero count, taken while idle, clears all lane accumulators and raises `elem_ready_o` in the next cycle.
- R3: Lane j of a beat is bits [j*DW +: DW] of `elem_data_i` and is added to lane accumulator j. The result equals the sum of the first `count_i` elements in stream order.
- R4: In the final beat, lanes whose element index (beat*VL + j) is at or beyond the count add nothing, whatever their data.
- R5: `elem_ready_o` falls in the cycle after the final beat is accepted. `sum_valid_o` is high in the cycle after the log2(VL)-th rising edge following the accepting edge.
- R6: `sum_valid_o` lasts exactly one cycle, and `sum_o` holds its value until the next result.
- R7: The sum wraps modulo 2^DW.
- R8: A count of zero never raises `elem_ready_o` and yields 0. The result valid comes log2(VL) edges after the start edge, counting as in R5.
- R9: A start pulse during accumulation or folding is ignored. Beats offered while `elem_ready_o` is low are not consumed, and stalls with `elem_valid_i` low add nothing.
- R10: A start pulse in the same cycle as `sum_valid_o` is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Job start strobe, taken only while idle |
| count_i | input | CNTW | Total element count, sampled with the start strobe |
| elem_valid_i | input | 1 | A beat of VL elements is offered |
| elem_ready_o | output | 1 | The block takes the offered beat at this edge |
| elem_data_i | input | VL*DW | VL elements, lane j in bits [j*DW +: DW] |
| sum_o | output | DW | Final sum, held until the next result |
| sum_valid_o | output | 1 | One-cycle pulse marking a new `sum_o` |

## Verification
Two things can fall into one cycle: presenting a finished result and taking a new start, and a start strobe arriving while a job is still accumulating or folding. The bench raises `start_i` in the exact cycle in which it sees `sum_valid_o`, and requires that the new job's stream is accepted at once. It also pulses `start_i` with a different count in the middle of a stream and again during the first fold, and requires that the sum and the fold latency are unchanged and that no extra result or ready appears afterwards. Every result is compared by a monitor against a queue of sums that the driver computed from the count and the data it sent.

// File: rtl/vred_pkg.sv
package vred_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FOLD = 2'd2
  } vred_state_e;
endpackage

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
#(
  parameter int VL    = 8,
  parameter int CNTW  = 16,
  parameter int STEPS = 3,
  parameter int SW    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [CNTW-1:0] count_i,
  input  logic            elem_valid_i,
  output logic            ready_o,
  output logic [VL-1:0]   lane_mask_o,
  output logic            clear_o,
  output logic            acc_en_o,
  output logic            fold_en_o,
  output logic [SW-1:0]   fold_idx_o,
  output logic            done_o,
  output logic            busy_o
);
  localparam logic [CNTW-1:0] VL_C = CNTW'(VL);

  vred_state_e     state_q;
  logic [CNTW-1:0] rem_q;
  logic [SW-1:0]   step_q;
  logic            last_beat;

  assign last_beat  = (rem_q <= VL_C);
  assign ready_o    = (state_q == ST_ACC);
  assign clear_o    = (state_q == ST_IDLE) && start_i;
  assign acc_en_o   = ready_o && elem_valid_i;
  assign fold_en_o  = (state_q == ST_FOLD);
  assign fold_idx_o = step_q;
  assign done_o     = fold_en_o && (step_q == SW'(STEPS - 1));
  assign busy_o     = (state_q != ST_IDLE);

  // a lane takes data only while its element index is below the remaining count
  for (genvar j = 0; j < VL; j++) begin : g_mask
    assign lane_mask_o[j] = (CNTW'(j) < rem_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rem_q   <= count_i;
            step_q  <= '0;
            state_q <= (count_i == '0) ? ST_FOLD : ST_ACC;
          end
        end
        ST_ACC: begin
          if (elem_valid_i) begin
            rem_q <= last_beat ? '0 : rem_q - VL_C;
            if (last_beat) state_q <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          step_q <= step_q + 1'b1;
          if (step_q == SW'(STEPS - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vred_lanes.sv
module vred_lanes #(
  parameter int DW = 32,
  parameter int VL = 8,
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            acc_en_i,
  input  logic [VL-1:0]   lane_mask_i,
  input  logic [VL*DW-1:0] chunk_i,
  input  logic            fold_en_i,
  input  logic [SW-1:0]   fold_idx_i,
  output logic [DW-1:0]   head_o
);
  localparam int IW = (VL > 1) ? $clog2(VL) : 1;

  logic [DW-1:0] part_q [VL];
  logic [DW-1:0] fold_d [VL];

  // one fold: the upper half of the active range lands on the lower half
  always_comb begin
    int half;
    half = VL >> (int'(fold_idx_i) + 1);
    for (int i = 0; i < VL; i++) begin
      if (i < half) fold_d[i] = part_q[i] + part_q[IW'(i + half)];
      else          fold_d[i] = part_q[i];
    end
  end

  assign head_o = fold_d[0];

  for (genvar j = 0; j < VL; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear_i)                  part_q[j] <= '0;
      else if (acc_en_i && lane_mask_i[j]) part_q[j] <= part_q[j] + chunk_i[j*DW +: DW];
      else if (fold_en_i)                  part_q[j] <= fold_d[j];
    end
  end
endmodule

// File: rtl/vec_tree_reduce.sv
module vec_tree_reduce #(
  parameter int DW   = 32,
  parameter int VL   = 8,
  parameter int CNTW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNTW-1:0]  count_i,
  input  logic             elem_valid_i,
  output logic             elem_ready_o,
  input  logic [VL*DW-1:0] elem_data_i,
  output logic [DW-1:0]    sum_o,
  output logic             sum_valid_o
);
  localparam int LOG2VL = $clog2(VL);
  localparam int STEPS  = (LOG2VL == 0) ? 1 : LOG2VL;
  localparam int SW     = $clog2(STEPS + 1);

  logic [VL-1:0] lane_mask;
  logic          clear, acc_en, fold_en, done, busy;
  logic [SW-1:0] fold_idx;
  logic [DW-1:0] head;

  vred_ctrl #(.VL(VL), .CNTW(CNTW), .STEPS(STEPS), .SW(SW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .count_i      (count_i),
    .elem_valid_i (elem_valid_i),
    .ready_o      (elem_ready_o),
    .lane_mask_o  (lane_mask),
    .clear_o      (clear),
    .acc_en_o     (acc_en),
    .fold_en_o    (fold_en),
    .fold_idx_o   (fold_idx),
    .done_o       (done),
    .busy_o       (busy)
  );

  vred_lanes #(.DW(DW), .VL(VL), .SW(SW)) u_lanes (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (clear),
    .acc_en_i    (acc_en),
    .lane_mask_i (lane_mask),
    .chunk_i     (elem_data_i),
    .fold_en_i   (fold_en),
    .fold_idx_i  (fold_idx),
    .head_o      (head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o       <= '0;
      sum_valid_o <= 1'b0;
    end else begin
      sum_valid_o <= done;
      if (done) sum_o <= head;
    end
  end
endmodule

// File: rtl/vred_checker.sv
module vred_checker #(
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [CNTW-1:0] count_i,
  input logic            elem_ready_o,
  input logic [DW-1:0]   sum_o,
  input logic            sum_valid_o,
  input logic            busy
);
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    sum_valid_o |=> !sum_valid_o);                                   // R6
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sum_valid_o |-> $stable(sum_o));                                // R6
  AST_READY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(elem_ready_o) |-> $past(start_i));                         // R2
  AST_ZERO_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && count_i == '0) |=> !elem_ready_o);          // R8
  AST_FOLD_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && !elem_ready_o) |=> !elem_ready_o);                      // R9
  AST_RESULT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    sum_valid_o |-> !elem_ready_o);                                  // R5
endmodule

bind vec_tree_reduce vred_checker #(.DW(DW), .CNTW(CNTW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .count_i      (count_i),
  .elem_ready_o (elem_ready_o),
  .sum_o        (sum_o),
  .sum_valid_o  (sum_valid_o),
  .busy         (busy)
);

// File: tb/sim_vec_tree_reduce.sv
`timescale 1ns/1ps
module sim_vec_tree_reduce;
  localparam int DW = 32, VL = 8, CNTW = 16, LOG2VL = 3;

  logic clk = 0, rst = 1, start_i = 0, elem_valid_i = 0;
  logic [CNTW-1:0]  count_i = '0;
  logic [VL*DW-1:0] elem_data_i = '0;
  logic elem_ready_o, sum_valid_o;
  logic [DW-1:0] sum_o;

  int checks = 0, bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_exp = '0;
  bit prev_valid = 0;

  always #2.5 clk = ~clk;

  vec_tree_reduce #(.DW(DW), .VL(VL), .CNTW(CNTW)) u0 (.*);

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] elem(int seed, int i);
    if (seed == 0) return 32'hFFFF_FFF0 + DW'(i);
    return DW'(seed) * 32'h0100_0193 + DW'(i) * 32'h9E37 + 32'd5;
  endfunction

  // monitor: compare every result against the scoreboard, and check the pulse width
  always @(negedge clk) begin
    if (!rst) begin
      if (sum_valid_o) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected result", sum_o, '0);
        else begin
          last_exp = exp_q.pop_front();
          check(sum_o == last_exp, "R3 sum", sum_o, last_exp);
        end
        if (prev_valid) check(0, "R6 pulse wider than one cycle", 1, 0);
      end
      prev_valid = sum_valid_o;
    end
  end

  function automatic logic [DW-1:0] expect_sum(int count, int seed);
    logic [DW-1:0] s = '0;
    for (int i = 0; i < count; i++) s += elem(seed, i);
    return s;
  endfunction

  // entered at the negedge after the start edge; leaves at the negedge showing sum_valid_o
  task automatic job_body(int count, int seed, int gap, bit spur);
    int n;
    if (count == 0) begin
      check(elem_ready_o == 0, "R8 ready with zero count", elem_ready_o, 0);
    end else begin
      check(elem_ready_o == 1, "R2 ready after start", elem_ready_o, 1);
      for (int b = 0; b < (count + VL - 1) / VL; b++) begin
        for (int j = 0; j < VL; j++) begin
          int idx = b * VL + j;
          elem_data_i[j*DW +: DW] = (idx < count) ? elem(seed, idx) : (32'hDEAD_0000 | DW'(idx)); // R4 garbage
        end
        elem_valid_i = 1;
        if (spur && b == 0) begin start_i = 1; count_i = 16'd3; end // R9
        while (!elem_ready_o) @(negedge clk);
        @(negedge clk);
        start_i = 0;
        elem_valid_i = 0;
        if (gap > 0 && b + 1 < (count + VL - 1) / VL) repeat (gap) @(negedge clk);
      end
      check(elem_ready_o == 0, "R5 ready drops after last beat", elem_ready_o, 0);
    end
    n = 1;
    if (spur) start_i = 1; // R9 start during the first fold
    while (!sum_valid_o && n < 60) begin
      @(negedge clk);
      start_i = 0;
      n++;
    end
    start_i = 0;
    check(n == LOG2VL + 1, count == 0 ? "R8 latency" : "R5 latency", n, LOG2VL + 1);
  endtask

  task automatic run_job(int count, int seed, int gap, bit spur);
    exp_q.push_back(expect_sum(count, seed));
    @(negedge clk);
    start_i = 1; count_i = CNTW'(count);
    @(negedge clk);
    start_i = 0;
    job_body(count, seed, gap, spur);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(sum_valid_o == 0 && elem_ready_o == 0, "R1 in reset", {sum_valid_o, elem_ready_o}, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(sum_valid_o == 0 && elem_ready_o == 0, "R1 after reset", {sum_valid_o, elem_ready_o}, 0);

    // R9: beats offered while idle are not consumed
    elem_valid_i = 1; elem_data_i = '1;
    repeat (3) @(negedge clk);
    elem_valid_i = 0;

    run_job(8, 3, 0, 0);    // R3 one full beat
    run_job(13, 7, 0, 0);   // R4 partial final beat
    run_job(1, 11, 0, 0);   // R4 single element
    run_job(64, 5, 2, 0);   // R3 many beats with stalls (R9)
    run_job(20, 0, 0, 0);   // R7 wrapping sum
    run_job(0, 1, 0, 0);    // R8 zero count
    run_job(17, 9, 1, 1);   // R9 spurious starts

    repeat (6) begin
      @(negedge clk);
      check(elem_ready_o == 0 && sum_valid_o == 0, "R9 no job from ignored start",
            {elem_ready_o, sum_valid_o}, 0);
    end
    check(sum_o == last_exp, "R6 sum held", sum_o, last_exp);

    // R10: start in the same cycle as the result pulse
    run_job(10, 21, 0, 0);
    exp_q.push_back(expect_sum(12, 33));
    start_i = 1; count_i = 16'd12;
    @(negedge clk);
    start_i = 0;
    check(elem_ready_o == 1, "R10 back-to-back start", elem_ready_o, 1);
    job_body(12, 33, 0, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule